// File: doc/BRIEF.md
# Serial Port Processor Register Interface

This block sits between a processor's 8-bit three-state I/O bus and the rest of a small serial port. The processor selects the block with a chip select. It picks one of four register slots with a 2-bit address and sets the transfer direction with a read/write line, where 1 means read. A transfer lasts one clock cycle and is taken on the next rising edge.

On a read, the block drives the bus for as long as the select-and-read condition holds. It drives either the receive byte or a status byte built live from two flags. Those flags are held by the receiver and transmitter, not here. On a write, the block latches the bus byte and raises a one-cycle load strobe toward the addressed target: the transmit buffer, or the low or high divisor byte. A read of the receive slot raises a one-cycle strobe that tells the receiver to drop its data-available flag. The transmitter lowers its own ready flag when a load arrives that it cannot take.

The two flags are also brought out as direct pins, so they can serve as interrupt sources.

Top module: `sbus_regif`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every strobe output (`tx_load`, `div_lo_load`, `div_hi_load`, `rx_taken`) is 0.
- R2: A read (cs=1, rw=1) at address 0 drives `rx_byte` onto `io_data` during the same cycle.
- R3: A read at address 1 drives the status byte onto `io_data`. Bit 0 is `rx_avail`, bit 1 is `tx_ready`, and bits 7..2 are 0. The bits follow the flag inputs in the same cycle.
- R4: A read at address 2 or 3 drives 8'h00 onto `io_data`.
- R5: A write (cs=1, rw=0) at address 0 makes `tx_load` 1 in the following cycle, with `wr_byte` equal to the written byte.
- R6: A write at address 2 pulses `div_lo_load`, and a write at address 3 pulses `div_hi_load`. Each pulse comes in the following cycle, with `wr_byte` holding the written byte.
- R7: A read at address 0 pulses `rx_taken` in the following cycle. Reads at addresses 1, 2 and 3 pulse no strobe.
- R8: A write at address 1 is ignored: no strobe is produced and `wr_byte` keeps its prior value.
- R9: While cs=0, the block does not drive `io_data`, produces no strobe, and leaves `wr_byte` unchanged, whatever rw and the address are.
- R10: During a write, the block does not drive `io_data`, so the byte another driver places on the bus is seen intact.
- R11: `rda_irq` equals `rx_avail` and `tbr_irq` equals `tx_ready` at all times.
- R12: Each strobe lasts exactly one cycle per transfer, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs | input | 1 | Chip select for one-cycle transfers |
| rw | input | 1 | Transfer direction: 1 read, 0 write |
| addr | input | 2 | Register slot select |
| io_data | inout | 8 | Three-state processor data bus |
| rx_byte | input | 8 | Byte held by the receiver |
| rx_avail | input | 1 | Receiver data-available flag |
| tx_ready | input | 1 | Transmitter ready-for-data flag |
| tx_load | output | 1 | One-cycle load strobe for the transmit buffer |
| div_lo_load | output | 1 | One-cycle load strobe for the divisor low byte |
| div_hi_load | output | 1 | One-cycle load strobe for the divisor high byte |
| rx_taken | output | 1 | One-cycle strobe clearing the data-available flag |
| wr_byte | output | 8 | Last accepted write byte, valid with any load strobe |
| rda_irq | output | 1 | Direct copy of the data-available flag |
| tbr_irq | output | 1 | Direct copy of the transmit-ready flag |

## Verification
The assertions assume that `cs`, `rw` and `addr` are stable across each rising edge. They also assume that nothing else drives `io_data` while a select-and-read is present. With these assumptions, a strobe in one cycle can be traced to the transfer sampled on the edge before it. The bench changes every input only on the falling edge. It releases its own bus driver before it raises `rw` with `cs`, and it drives the bus only for writes or while the block is deselected.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int SLOT_W = 2;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_DATA  = 2'b00,
    SLOT_STAT  = 2'b01,
    SLOT_DIVLO = 2'b10,
    SLOT_DIVHI = 2'b11
  } slot_e;

  typedef struct packed {
    logic tx_wr;
    logic rx_rd;
    logic dlo_wr;
    logic dhi_wr;
  } strobe_s;

  localparam int STROBE_W = $bits(strobe_s);
endpackage

// File: rtl/sbus_decode.sv
module sbus_decode
  import sbus_pkg::*;
(
  input  logic              cs,
  input  logic              rw,
  input  logic [SLOT_W-1:0] addr,
  output strobe_s           req,
  output logic              rd_en
);
  logic wr_sel;
  logic rd_sel;

  always_comb begin
    wr_sel     = cs & ~rw;
    rd_sel     = cs & rw;
    req        = '0;
    req.tx_wr  = wr_sel & (addr == SLOT_DATA);
    req.dlo_wr = wr_sel & (addr == SLOT_DIVLO);
    req.dhi_wr = wr_sel & (addr == SLOT_DIVHI);
    req.rx_rd  = rd_sel & (addr == SLOT_DATA);
    rd_en      = rd_sel;
  end
endmodule

// File: rtl/sbus_strobe.sv
module sbus_strobe
  import sbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_s           req,
  input  logic [DATA_W-1:0] wr_data,
  output strobe_s           strb_q,
  output logic [DATA_W-1:0] wr_byte_q
);
  strobe_s           strb_d;
  logic [DATA_W-1:0] wr_byte_d;
  logic              load_en;

  always_comb begin
    load_en   = req.tx_wr | req.dlo_wr | req.dhi_wr;
    strb_d    = req;
    wr_byte_d = wr_byte_q;
    if (load_en) begin
      wr_byte_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= '0;
    end else begin
      strb_q <= strb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_byte_q <= '0;
    end else if (load_en) begin
      wr_byte_q <= wr_byte_d;
    end
  end

  p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb_q));
endmodule

// File: rtl/sbus_rdmux.sv
module sbus_rdmux
  import sbus_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int RDA_POS = 0,
  parameter int TBR_POS = 1
) (
  input  logic [SLOT_W-1:0] addr,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_avail,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] stat_word;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_stat
    if (gi == RDA_POS) begin : g_rda
      assign stat_word[gi] = rx_avail;
    end else if (gi == TBR_POS) begin : g_tbr
      assign stat_word[gi] = tx_ready;
    end else begin : g_zero
      assign stat_word[gi] = 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      SLOT_DATA: rd_word = rx_byte;
      SLOT_STAT: rd_word = stat_word;
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/sbus_regif.sv
module sbus_regif
  import sbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rw,
  input  logic [1:0]        addr,
  inout  wire  [DATA_W-1:0] io_data,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_avail,
  input  logic              tx_ready,
  output logic              tx_load,
  output logic              div_lo_load,
  output logic              div_hi_load,
  output logic              rx_taken,
  output logic [DATA_W-1:0] wr_byte,
  output logic              rda_irq,
  output logic              tbr_irq
);
  strobe_s           req;
  strobe_s           strb_q;
  logic              rd_en;
  logic [DATA_W-1:0] rd_word;

  sbus_decode u_decode (
    .cs    (cs),
    .rw    (rw),
    .addr  (addr),
    .req   (req),
    .rd_en (rd_en)
  );

  sbus_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr_data   (io_data),
    .strb_q    (strb_q),
    .wr_byte_q (wr_byte)
  );

  sbus_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .addr     (addr),
    .rx_byte  (rx_byte),
    .rx_avail (rx_avail),
    .tx_ready (tx_ready),
    .rd_word  (rd_word)
  );

  assign io_data     = rd_en ? rd_word : {DATA_W{1'bz}};
  assign tx_load     = strb_q.tx_wr;
  assign div_lo_load = strb_q.dlo_wr;
  assign div_hi_load = strb_q.dhi_wr;
  assign rx_taken    = strb_q.rx_rd;
  assign rda_irq     = rx_avail;
  assign tbr_irq     = tx_ready;

  p_tx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !rw && addr == SLOT_DATA) |=> (tx_load && wr_byte == $past(io_data)));

  p_rx_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rw && addr == SLOT_DATA) |=> (rx_taken && !tx_load));

  p_stat_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !rw && addr == SLOT_STAT) |=>
      (!tx_load && !div_lo_load && !div_hi_load && !rx_taken && $stable(wr_byte)));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> (!tx_load && !div_lo_load && !div_hi_load && !rx_taken && $stable(wr_byte)));
endmodule

// File: tb/test_sbus_regif.sv
`timescale 1ns/1ps
module test_sbus_regif;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, rw;
  logic [1:0] addr;
  logic [7:0] rx_byte;
  logic       rx_avail, tx_ready;
  logic       tb_oe;
  logic [7:0] tb_drv;
  wire  [7:0] io_data;
  logic       tx_load, div_lo_load, div_hi_load, rx_taken;
  logic [7:0] wr_byte;
  logic       rda_irq, tbr_irq;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  assign io_data = tb_oe ? tb_drv : 8'hzz;

  sbus_regif i_sbus_regif (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .addr(addr),
    .io_data(io_data), .rx_byte(rx_byte), .rx_avail(rx_avail),
    .tx_ready(tx_ready), .tx_load(tx_load), .div_lo_load(div_lo_load),
    .div_hi_load(div_hi_load), .rx_taken(rx_taken), .wr_byte(wr_byte),
    .rda_irq(rda_irq), .tbr_irq(tbr_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] strobes();
    return {tx_load, div_lo_load, div_hi_load, rx_taken};
  endfunction

  task automatic go_idle();
    @(negedge clk);
    cs = 1'b0; rw = 1'b0; addr = 2'd0; tb_oe = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cs = 1'b0; rw = 1'b0; addr = 2'd0; tb_oe = 1'b0; tb_drv = 8'h00;
    rx_byte = 8'h00; rx_avail = 1'b0; tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R1 strobes in reset", {28'd0, strobes()}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 strobes after reset", {28'd0, strobes()}, 32'd0);
  endtask

  task automatic t_read_rx(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b; cs = 1'b1; rw = 1'b1; addr = 2'd0; tb_oe = 1'b0;
    #1 chk("R2 rx byte on bus", {24'd0, io_data}, {24'd0, b});
    @(negedge clk);
    cs = 1'b0; rw = 1'b0;
    #1 chk("R7 rx_taken pulse", {28'd0, strobes()}, 32'd1);
    @(negedge clk);
    #1 chk("R12 rx_taken single cycle", {28'd0, strobes()}, 32'd0);
  endtask

  task automatic t_read_status();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rx_avail = k[0]; tx_ready = k[1];
      cs = 1'b1; rw = 1'b1; addr = 2'd1; tb_oe = 1'b0;
      #1 chk("R3 status byte", {24'd0, io_data}, {30'd0, k[1], k[0]});
      chk("R11 direct flag pins", {30'd0, tbr_irq, rda_irq}, {30'd0, k[1], k[0]});
      @(negedge clk);
      cs = 1'b0; rw = 1'b0;
      #1 chk("R7 no strobe on status read", {28'd0, strobes()}, 32'd0);
    end
  endtask

  task automatic t_read_div();
    for (int a = 2; a < 4; a++) begin
      @(negedge clk);
      cs = 1'b1; rw = 1'b1; addr = a[1:0]; tb_oe = 1'b0;
      #1 chk("R4 divisor slot reads zero", {24'd0, io_data}, 32'd0);
      @(negedge clk);
      cs = 1'b0; rw = 1'b0;
      #1 chk("R7 no strobe on divisor read", {28'd0, strobes()}, 32'd0);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] b);
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; addr = a; tb_oe = 1'b1; tb_drv = b;
    #1 chk("R10 bus not driven during write", {24'd0, io_data}, {24'd0, b});
    @(negedge clk);
    cs = 1'b0; tb_oe = 1'b0;
  endtask

  task automatic t_write_tx(input logic [7:0] b);
    do_write(2'd0, b);
    #1 chk("R5 tx_load pulse", {28'd0, strobes()}, 32'd8);
    chk("R5 tx byte", {24'd0, wr_byte}, {24'd0, b});
    @(negedge clk);
    #1 chk("R12 tx_load single cycle", {28'd0, strobes()}, 32'd0);
  endtask

  task automatic t_write_div(input logic [7:0] lo, input logic [7:0] hi);
    do_write(2'd2, lo);
    #1 chk("R6 div_lo_load pulse", {28'd0, strobes()}, 32'd4);
    chk("R6 low byte", {24'd0, wr_byte}, {24'd0, lo});
    do_write(2'd3, hi);
    #1 chk("R6 div_hi_load pulse", {28'd0, strobes()}, 32'd2);
    chk("R6 high byte", {24'd0, wr_byte}, {24'd0, hi});
  endtask

  task automatic t_write_status(input logic [7:0] held);
    do_write(2'd1, 8'hFF);
    #1 chk("R8 status write no strobe", {28'd0, strobes()}, 32'd0);
    chk("R8 status write byte kept", {24'd0, wr_byte}, {24'd0, held});
  endtask

  task automatic t_idle(input logic [7:0] held);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cs = 1'b0; rw = k[0]; addr = k[2:1]; tb_oe = 1'b1; tb_drv = 8'h3C;
      #1 chk("R9 deselected bus untouched", {24'd0, io_data}, 32'h3C);
      @(negedge clk);
      tb_oe = 1'b0; rw = 1'b0;
      #1 chk("R9 deselected no strobe", {28'd0, strobes()}, 32'd0);
      chk("R9 deselected byte kept", {24'd0, wr_byte}, {24'd0, held});
    end
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; addr = 2'd0; tb_oe = 1'b1; tb_drv = 8'h11;
    @(negedge clk);
    tb_drv = 8'h22;
    #1 chk("R12 first of two writes", {20'd0, strobes(), wr_byte}, {20'd0, 4'd8, 8'h11});
    @(negedge clk);
    cs = 1'b0; tb_oe = 1'b0;
    #1 chk("R5 second of two writes", {20'd0, strobes(), wr_byte}, {20'd0, 4'd8, 8'h22});
    @(negedge clk);
    #1 chk("R12 pulses end", {28'd0, strobes()}, 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_read_rx(8'h5A);
    t_read_rx(8'hC3);
    t_read_status();
    t_read_div();
    t_write_tx(8'hA3);
    t_write_div(8'h11, 8'h7E);
    t_write_status(8'h7E);
    t_idle(8'h7E);
    t_back_to_back();
    go_idle();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule